// File: doc/BRIEF.md
# Ultra DMA Arm/Disarm and Status Condensing Unit

This unit is a small register block that sits between a host bus and an Ultra DMA transfer engine. The host uses it to set the transfer direction and to start the engine. It also programs the interface configuration, which covers interface enable, the transfer-class select and a mode number. Finally, it reads back the engine condition, both as a raw status word and as a two-bit summary. The burst protocol on the disk cable and the system DMA controller are outside this unit. Both appear only as status inputs and a request output.

The enable bit is protected by a handshake. The host first writes the direction with enable clear. It then reads the operation register back, and only after that may it set enable with the same direction. Any other attempt to set enable is dropped. Stopping a transfer clears the operation register completely. It also raises both drive strobes and both chip selects on the bus control outputs, and returns the configuration to PIO in the most recently programmed PIO mode and hold count. Engine error flags are sticky. They stay set until the operation register is cleared.

The summary has a fixed priority. Any error beats a device interrupt, and a device interrupt beats an engine that is busy or requesting data.

Top module: `udma_arm_unit`

## Requirements
- R1: After reset the bus control register (offset 0x00) reads 0x63, so both chip selects and both strobes are high. The configuration register (0x04) and the operation register (0x0C) read 0, and the summary is 0 (idle).
- R2: Enable becomes 1 only through three steps in order: a write of the direction with bit 0 clear, then a read of offset 0x0C, then a write with bit 0 set that carries the same direction.
- R3: A write that sets enable without the preceding read, or with a direction that differs from the primed one, is ignored. Enable stays 0 and the stored direction is unchanged.
- R4: In the operation register, bit 0 is enable and bit 1 is direction, where 1 means host to device. The `udmaEnable` and `udmaToDevice` outputs follow these bits, and the direction cannot change while enable is set.
- R5: A write with bit 0 clear while enable is set is a stop. It clears the whole operation register. It forces bus control bits 0, 1, 5 and 6 high and keeps the address bits [4:2].
- R6: A stop loads the configuration with bits 0 and 1 set and bits 2 and 3 clear. Mode [7:4] and hold [9:8] come from the last configuration write that had bit 1 (PIO) set.
- R7: The status word at 0x28 shows the engine request at bit 16, the engine error interrupt at bit 17 and busy at bit 18. It shows unfinished data-out at bit 24, unfinished data-in at bit 25 and a length that is not a multiple of four words at bit 26. All other bits read 0.
- R8: Status bits 17, 24, 25 and 26 stay set after their inputs fall. They clear only when the operation register becomes 0, either through a write of 0 or through a stop. A write of direction 1 with enable clear leaves them set.
- R9: The summary `condStat` is 3 when any of bits 17, 24, 25 or 26 is set. Otherwise it is 2 when the device interrupt input is high. Otherwise it is 1 when busy or the engine request is set. Otherwise it is 0.
- R10: `dmaReq` follows the engine request only while enable is set.
- R11: Bus control bits [6:0] are writable and drive the outputs: chip selects at [1:0], address at [4:2], read strobe at 5 and write strobe at 6. Bit 9 of a bus control read shows the device interrupt input.
- R12: A read of any unmapped offset (for example 0x30) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 8 | Byte offset of the accessed register |
| regWrData | input | 10 | Write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| engDmaReq | input | 1 | Engine data request |
| engErrIrq | input | 1 | Engine error interrupt |
| engBusy | input | 1 | Engine not idle |
| engNoDataOut | input | 1 | Data-out did not complete |
| engNoDataIn | input | 1 | Data-in did not complete |
| engNot4x | input | 1 | Length not a multiple of four words |
| devIntrq | input | 1 | Device interrupt line |
| dmaReq | output | 1 | Gated request to the system DMA controller |
| udmaEnable | output | 1 | Engine enabled |
| udmaToDevice | output | 1 | Direction, 1 = host to device |
| xferCfg | output | 10 | Configuration register contents |
| ideCsN | output | 2 | Chip selects, active low |
| ideAddr | output | 3 | Device register address |
| ideRdN | output | 1 | Read strobe, active low |
| ideWrN | output | 1 | Write strobe, active low |
| condStat | output | 2 | Summary: 3 error, 2 interrupt, 1 active, 0 idle |

## Verification
The embedded properties assume the following about the inputs:
- at most one register access per cycle, with read and write never strobed together;
- engine status and interrupt inputs change synchronously and are known from reset.

The stimulus respects these assumptions. Every input and every access strobe changes only on the falling clock edge. Each access lasts exactly one cycle, and a read never overlaps a write. Flags are raised for at least one rising edge so that the sticky capture is actually exercised before they fall.

// File: rtl/udma_arm_pkg.sv
package udma_arm_pkg;

  // register byte offsets
  localparam int OFS_BUSCTL = 'h00;
  localparam int OFS_CFG    = 'h04;
  localparam int OFS_OPER   = 'h0C;
  localparam int OFS_STAT   = 'h28;

  // status word bit positions
  localparam int STS_REQ_BIT   = 16;
  localparam int STS_EIRQ_BIT  = 17;
  localparam int STS_BUSY_BIT  = 18;
  localparam int STS_NOOUT_BIT = 24;
  localparam int STS_NOIN_BIT  = 25;
  localparam int STS_N4X_BIT   = 26;

  // bus control register layout
  localparam int            CTL_W        = 7;
  localparam logic [CTL_W-1:0] CTL_IDLE  = 7'h63;
  localparam int            CTL_INTRQ_BIT = 9;

  typedef enum logic [1:0] {
    COND_IDLE   = 2'd0,
    COND_ACTIVE = 2'd1,
    COND_INTR   = 2'd2,
    COND_ERROR  = 2'd3
  } condStat_e;

  typedef enum logic [1:0] {
    ARM_IDLE   = 2'd0,
    ARM_PRIMED = 2'd1,
    ARM_READ   = 2'd2
  } armState_e;

  // strobes from the control FSM into the register datapath
  typedef struct packed {
    logic ctrlWr;
    logic cfgWr;
    logic primeOp;
    logic armOp;
    logic stopOp;
    logic clrSticky;
  } strobes_t;

endpackage

// File: rtl/udma_arm_ctrl.sv
module udma_arm_ctrl
  import udma_arm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEnBit,
  input  logic              wrDirBit,
  input  logic              opEnable,
  input  logic              opDir,
  output strobes_t          strb
);

  armState_e armState, armNext;
  logic opWr, opRd;

  assign opWr = wrEn && (addr == ADDR_W'(OFS_OPER));
  assign opRd = rdEn && !wrEn && (addr == ADDR_W'(OFS_OPER));

  always_comb begin
    strb.ctrlWr    = wrEn && (addr == ADDR_W'(OFS_BUSCTL));
    strb.cfgWr     = wrEn && (addr == ADDR_W'(OFS_CFG));
    strb.stopOp    = opWr && opEnable && !wrEnBit;
    strb.primeOp   = opWr && !opEnable && !wrEnBit;
    strb.armOp     = opWr && !opEnable && wrEnBit &&
                     (armState == ARM_READ) && (wrDirBit == opDir);
    strb.clrSticky = strb.stopOp || (strb.primeOp && !wrDirBit);
  end

  always_comb begin
    armNext = armState;
    if (opWr)
      armNext = strb.primeOp ? ARM_PRIMED : ARM_IDLE;
    else if (opRd && armState == ARM_PRIMED)
      armNext = ARM_READ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) armState <= ARM_IDLE;
    else       armState <= armNext;
  end

  // R3
  lone_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opWr && wrEnBit && !opEnable && armState != ARM_READ) |=> !opEnable);

  // R2
  arm_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(opEnable) |-> ($past(armState) == ARM_READ));

  // R4
  dir_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opEnable && $past(opEnable)) |-> $stable(opDir));

endmodule

// File: rtl/udma_arm_dpath.sv
module udma_arm_dpath
  import udma_arm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int MODE_W = 4,
  parameter int HOLD_W = 2,
  localparam int CFG_W = 4 + MODE_W + HOLD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  wrData,
  input  logic              engDmaReq,
  input  logic              engErrIrq,
  input  logic              engBusy,
  input  logic              engNoDataOut,
  input  logic              engNoDataIn,
  input  logic              engNot4x,
  input  logic              devIntrq,
  output logic [DATA_W-1:0] rdData,
  output logic              opEnable,
  output logic              opDir,
  output logic [CTL_W-1:0]  busCtl,
  output logic [CFG_W-1:0]  cfgReg,
  output logic              dmaReq,
  output condStat_e         condStat
);

  localparam int ERR_N     = 4;
  localparam int MODE_LSB  = 4;
  localparam int PIO_BIT   = 1;
  localparam logic [3:0] CFG_PIO_ON = 4'b0011;

  logic [MODE_W+HOLD_W-1:0] pioTiming;
  logic [ERR_N-1:0] errLive, errSticky, errSeen;
  logic [DATA_W-1:0] stsWord;

  // bus control register
  always_ff @(posedge clk) begin
    if (!rstN)              busCtl <= CTL_IDLE;
    else if (strb.stopOp)   busCtl <= busCtl | CTL_IDLE;
    else if (strb.ctrlWr)   busCtl <= wrData[CTL_W-1:0];
  end

  // configuration register and saved PIO timing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg    <= '0;
      pioTiming <= '0;
    end else begin
      if (strb.stopOp)
        cfgReg <= {pioTiming, CFG_PIO_ON};
      else if (strb.cfgWr)
        cfgReg <= wrData;
      if (strb.cfgWr && wrData[PIO_BIT])
        pioTiming <= wrData[CFG_W-1:MODE_LSB];
    end
  end

  // operation register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opEnable <= 1'b0;
      opDir    <= 1'b0;
    end else if (strb.stopOp) begin
      opEnable <= 1'b0;
      opDir    <= 1'b0;
    end else if (strb.primeOp) begin
      opEnable <= 1'b0;
      opDir    <= wrData[1];
    end else if (strb.armOp) begin
      opEnable <= 1'b1;
    end
  end

  // sticky error capture
  assign errLive = {engNot4x, engNoDataIn, engNoDataOut, engErrIrq};

  always_ff @(posedge clk) begin
    if (!rstN)               errSticky <= '0;
    else if (strb.clrSticky) errSticky <= '0;
    else                     errSticky <= errSticky | errLive;
  end

  assign errSeen = errSticky | errLive;

  always_comb begin
    stsWord                = '0;
    stsWord[STS_REQ_BIT]   = engDmaReq;
    stsWord[STS_EIRQ_BIT]  = errSeen[0];
    stsWord[STS_BUSY_BIT]  = engBusy;
    stsWord[STS_NOOUT_BIT] = errSeen[1];
    stsWord[STS_NOIN_BIT]  = errSeen[2];
    stsWord[STS_N4X_BIT]   = errSeen[3];
  end

  // condensed status, fixed priority
  always_comb begin
    if (|errSeen)                condStat = COND_ERROR;
    else if (devIntrq)           condStat = COND_INTR;
    else if (engBusy || engDmaReq) condStat = COND_ACTIVE;
    else                         condStat = COND_IDLE;
  end

  assign dmaReq = engDmaReq && opEnable;

  // read mux
  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(OFS_BUSCTL)) begin
      rdData[CTL_W-1:0]    = busCtl;
      rdData[CTL_INTRQ_BIT] = devIntrq;
    end else if (addr == ADDR_W'(OFS_CFG)) begin
      rdData[CFG_W-1:0] = cfgReg;
    end else if (addr == ADDR_W'(OFS_OPER)) begin
      rdData[1:0] = {opDir, opEnable};
    end else if (addr == ADDR_W'(OFS_STAT)) begin
      rdData = stsWord;
    end
  end

  // R5
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stopOp |=> (!opEnable && !opDir && busCtl[0] && busCtl[1] &&
                     busCtl[5] && busCtl[6]));

  // R6
  stop_to_pio_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stopOp |=> (cfgReg[3:0] == CFG_PIO_ON));

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(engNot4x) && !$past(strb.clrSticky)) |-> (condStat == COND_ERROR));

  // R10
  req_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engDmaReq && !opEnable) |-> !dmaReq);

endmodule

// File: rtl/udma_arm_unit.sv
module udma_arm_unit
  import udma_arm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int MODE_W = 4,
  parameter int HOLD_W = 2,
  localparam int CFG_W = 4 + MODE_W + HOLD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CFG_W-1:0]  regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              engDmaReq,
  input  logic              engErrIrq,
  input  logic              engBusy,
  input  logic              engNoDataOut,
  input  logic              engNoDataIn,
  input  logic              engNot4x,
  input  logic              devIntrq,
  output logic              dmaReq,
  output logic              udmaEnable,
  output logic              udmaToDevice,
  output logic [CFG_W-1:0]  xferCfg,
  output logic [1:0]        ideCsN,
  output logic [2:0]        ideAddr,
  output logic              ideRdN,
  output logic              ideWrN,
  output logic [1:0]        condStat
);

  strobes_t         strb;
  logic             opEnable, opDir;
  logic [CTL_W-1:0] busCtl;
  condStat_e        condVal;

  udma_arm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (regWrEn),
    .rdEn     (regRdEn),
    .addr     (regAddr),
    .wrEnBit  (regWrData[0]),
    .wrDirBit (regWrData[1]),
    .opEnable (opEnable),
    .opDir    (opDir),
    .strb     (strb)
  );

  udma_arm_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MODE_W (MODE_W),
    .HOLD_W (HOLD_W)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .addr         (regAddr),
    .wrData       (regWrData),
    .engDmaReq    (engDmaReq),
    .engErrIrq    (engErrIrq),
    .engBusy      (engBusy),
    .engNoDataOut (engNoDataOut),
    .engNoDataIn  (engNoDataIn),
    .engNot4x     (engNot4x),
    .devIntrq     (devIntrq),
    .rdData       (regRdData),
    .opEnable     (opEnable),
    .opDir        (opDir),
    .busCtl       (busCtl),
    .cfgReg       (xferCfg),
    .dmaReq       (dmaReq),
    .condStat     (condVal)
  );

  assign udmaEnable   = opEnable;
  assign udmaToDevice = opDir;
  assign ideCsN       = busCtl[1:0];
  assign ideAddr      = busCtl[4:2];
  assign ideRdN       = busCtl[5];
  assign ideWrN       = busCtl[6];
  assign condStat     = condVal;

endmodule

// File: tb/test_udma_arm_unit.sv
module test_udma_arm_unit;

  localparam time CLK_P = 20ns;
  localparam logic [7:0] A_CTL = 8'h00, A_CFG = 8'h04, A_OP = 8'h0C,
                         A_STS = 8'h28, A_NONE = 8'h30;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 0, regRdEn = 0;
  logic [7:0] regAddr = '0;
  logic [9:0] regWrData = '0;
  logic [31:0] regRdData;
  logic engDmaReq = 0, engErrIrq = 0, engBusy = 0, engNoDataOut = 0,
        engNoDataIn = 0, engNot4x = 0, devIntrq = 0;
  logic dmaReq, udmaEnable, udmaToDevice, ideRdN, ideWrN;
  logic [9:0] xferCfg;
  logic [1:0] ideCsN, condStat;
  logic [2:0] ideAddr;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  udma_arm_unit i_udma_arm_unit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .engDmaReq(engDmaReq), .engErrIrq(engErrIrq), .engBusy(engBusy),
    .engNoDataOut(engNoDataOut), .engNoDataIn(engNoDataIn),
    .engNot4x(engNot4x), .devIntrq(devIntrq), .dmaReq(dmaReq),
    .udmaEnable(udmaEnable), .udmaToDevice(udmaToDevice), .xferCfg(xferCfg),
    .ideCsN(ideCsN), .ideAddr(ideAddr), .ideRdN(ideRdN), .ideWrN(ideWrN),
    .condStat(condStat)
  );

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic doWrite(input logic [7:0] a, input logic [9:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [31:0] v);
    regRdEn = 1; regAddr = a;
    #1 v = regRdData;
    @(negedge clk);
    regRdEn = 0;
  endtask

  function automatic logic [1:0] expCond(input logic [6:0] s);
    // s: 0 req,1 eirq,2 busy,3 noOut,4 noIn,5 n4x,6 intrq
    if (s[1] | s[3] | s[4] | s[5]) return 2'd3;
    if (s[6])                      return 2'd2;
    if (s[0] | s[2])               return 2'd1;
    return 2'd0;
  endfunction

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [9:0] pioCfg;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    doRead(A_CTL, v); chkEq("R1 ctl", v, 32'h63);
    doRead(A_CFG, v); chkEq("R1 cfg", v, 0);
    doRead(A_OP, v);  chkEq("R1 op", v, 0);
    chkEq("R1 cond", condStat, 0);
    chkEq("R1 pins", {ideCsN, ideRdN, ideWrN}, 4'hF);

    // R11 bus control write and interrupt readback
    doWrite(A_CTL, 10'h01C);
    chkEq("R11 pins", {ideCsN, ideAddr, ideRdN, ideWrN}, {2'b00, 3'd7, 2'b00});
    devIntrq = 1;
    doRead(A_CTL, v); chkEq("R11 intrq", v, 32'h21C);
    devIntrq = 0;

    // R12 unmapped offset
    doRead(A_NONE, v); chkEq("R12 unmapped", v, 0);

    // R7 R8 R9 R10 exhaustive status sweep
    for (int s = 0; s < 128; s++) begin
      logic [6:0] b;
      logic [31:0] expSts, expErr;
      b = 7'(s);
      {devIntrq, engNot4x, engNoDataIn, engNoDataOut, engBusy, engErrIrq, engDmaReq} = b;
      expSts = (32'(b[0]) << 16) | (32'(b[1]) << 17) | (32'(b[2]) << 18) |
               (32'(b[3]) << 24) | (32'(b[4]) << 25) | (32'(b[5]) << 26);
      expErr = expSts & 32'h0702_0000;
      doRead(A_STS, v); chkEq("R7 status", v, expSts);
      chkEq("R9 cond", condStat, expCond(b));
      chkEq("R10 gated", dmaReq, 0);
      {devIntrq, engNot4x, engNoDataIn, engNoDataOut, engBusy, engErrIrq, engDmaReq} = '0;
      doRead(A_STS, v); chkEq("R8 sticky", v, expErr);
      chkEq("R8 cond", condStat, (expErr != 0) ? 2'd3 : 2'd0);
      doWrite(A_OP, 10'h000);
      doRead(A_STS, v); chkEq("R8 cleared", v, 0);
    end

    // R8 a direction-only write does not clear
    engNot4x = 1; @(negedge clk); engNot4x = 0;
    doWrite(A_OP, 10'h002);
    doRead(A_STS, v); chkEq("R8 kept", v, 32'h0400_0000);
    doWrite(A_OP, 10'h000);
    doRead(A_STS, v); chkEq("R8 zero clr", v, 0);

    // R2 R3 R4 R5 R6 arming sequences for both directions
    for (int d = 0; d < 2; d++) begin
      logic dir;
      dir = d[0];
      pioCfg = 10'((d + 1) << 8) | 10'((5 + d) << 4) | 10'h003;
      doWrite(A_CFG, pioCfg);
      doWrite(A_CTL, 10'h01C);
      // lone enable after prime
      doWrite(A_OP, {8'd0, dir, 1'b0});
      doWrite(A_OP, {8'd0, dir, 1'b1});
      chkEq("R3 no read", udmaEnable, 0);
      doRead(A_OP, v); chkEq("R3 op kept", v, {30'd0, dir, 1'b0});
      doWrite(A_OP, {8'd0, dir, 1'b1});
      chkEq("R3 idle enable", udmaEnable, 0);
      // direction mismatch
      doWrite(A_OP, {8'd0, dir, 1'b0});
      doRead(A_OP, v);
      doWrite(A_OP, {8'd0, ~dir, 1'b1});
      chkEq("R3 dir mismatch", udmaEnable, 0);
      doRead(A_OP, v); chkEq("R3 dir kept", v, {30'd0, dir, 1'b0});
      // proper sequence
      doWrite(A_OP, {8'd0, dir, 1'b0});
      doRead(A_OP, v); chkEq("R2 readback", v, {30'd0, dir, 1'b0});
      doWrite(A_OP, {8'd0, dir, 1'b1});
      chkEq("R2 armed", udmaEnable, 1);
      chkEq("R4 dir", udmaToDevice, dir);
      doRead(A_OP, v); chkEq("R4 op bits", v, {30'd0, dir, 1'b1});
      doWrite(A_CFG, 10'((2 + d) << 4) | 10'h009);
      engDmaReq = 1;
      #1 chkEq("R10 passes", dmaReq, 1);
      chkEq("R9 active", condStat, 1);
      @(negedge clk);
      engDmaReq = 0;
      // stop
      doWrite(A_OP, 10'h000);
      chkEq("R5 disabled", udmaEnable, 0);
      doRead(A_OP, v);  chkEq("R5 op zero", v, 0);
      doRead(A_CTL, v); chkEq("R5 ctl", v, 32'h7F);
      chkEq("R5 addr kept", ideAddr, 3'd7);
      doRead(A_CFG, v); chkEq("R6 pio cfg", v, 32'(pioCfg));
      chkEq("R9 idle", condStat, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule